// File: doc/BRIEF.md
# Imaging Front-End Clock Generator

This block sits on the host side of a three-colour image sensor front end and derives three timing waveforms from one fast system clock: a reference-level sample clock (its high phase also enables the input clamp, and its falling edge captures the reset level), a data-level sample clock (its falling edge captures the video level), and a conversion clock for the shared converter. A one-cycle pixel-start marker accompanies every rising edge of the data-level clock.

Two mode inputs select correlated-double-sampling or sample-and-hold operation, and three-channel or one-channel operation. In three-channel mode each pixel holds three conversion periods; in one-channel mode it holds two, one for each output byte. All edge positions and pulse widths are given as system clock counts on configuration inputs. The settings are captured while the generator is idle and again at each pixel boundary, and a setting that would break an edge-ordering rule or a minimum width or period raises an error flag and keeps all clocks low.

Top module: `afe_clkgen`

## Requirements
- R1: While reset is asserted, and on the first sample after it, all four outputs and `cfgErr` are low.
- R2: In three-channel mode a pixel is three conversion slots; in each slot `cnvClk` is low for `cnvLow` counts and then high for `cnvHigh` counts. The output for count k of a pixel appears on the clock edge that ends count k, and count 0 is the clock cycle after the edge on which `run` was sampled high.
- R3: `datClk` is high for `datWidth` counts beginning `datStart` counts into the first slot of each pixel, and falls no later than the rising edge of `cnvClk` in that slot.
- R4: In correlated-double-sampling mode (`cdsMode`=1) `refClk` is high for `refWidth` counts beginning `refStart` counts into the first slot, and falls no later than `datClk` rises; the two are never high together.
- R5: In sample-and-hold mode (`cdsMode`=0) `refClk` stays low and `refStart`/`refWidth` are not checked for errors.
- R6: `pixStart` is high for exactly one cycle, in the same cycle that `datClk` first goes high for a pixel.
- R7: `cfgErr` goes high and no clock toggles if `datWidth` < MIN_SAMPLE, `cnvLow` or `cnvHigh` < MIN_CONV, `datStart`+`datWidth` > `cnvLow`, the pixel period (slot length times slots per pixel) is below MIN_PIX_3CH (three-channel) or MIN_PIX_1CH (one-channel), or, in correlated-double-sampling mode, `refWidth` < MIN_SAMPLE or `refStart`+`refWidth` > `datStart`. Defaults: MIN_SAMPLE=1, MIN_CONV=2, MIN_PIX_3CH=12, MIN_PIX_1CH=10.
- R8: Changes to the mode and count inputs during a run take effect only at the next pixel boundary; `run` sampled low at the last count of a pixel stops the generator, and all outputs are low from the following cycle.
- R9: In one-channel mode (`threeCh`=0) a pixel is two conversion slots with the same slot shape as R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Generate clocks while high |
| cdsMode | input | 1 | 1 = correlated double sampling, 0 = sample-and-hold |
| threeCh | input | 1 | 1 = three slots per pixel, 0 = two |
| refStart | input | CNT_W | Reference clock rise, counts into slot 0 |
| refWidth | input | CNT_W | Reference clock high time in counts |
| datStart | input | CNT_W | Data clock rise, counts into slot 0 |
| datWidth | input | CNT_W | Data clock high time in counts |
| cnvLow | input | CNT_W | Conversion clock low phase in counts |
| cnvHigh | input | CNT_W | Conversion clock high phase in counts |
| refClk | output | 1 | Reference-level sample clock |
| datClk | output | 1 | Data-level sample clock |
| cnvClk | output | 1 | Conversion clock |
| pixStart | output | 1 | One-cycle pixel-start marker |
| cfgErr | output | 1 | Captured settings break a rule |

## Verification
The hardest situation to reach is a setting change that lands exactly on a pixel boundary while the generator is running, because the new slot count, mode and edge positions must all switch over on one edge with no partial pixel. The stimulus starts a run with one setting, changes the inputs in the last count of a chosen pixel and keeps a continuous expected stream spanning both settings, including a switch from three to two slots per pixel. Error cases are driven with edge positions placed one count past each ordering limit, next to runs that sit exactly on those limits.

// File: rtl/afe_clkgen_pkg.sv
`timescale 1ns/1ps
package afe_clkgen_pkg;
  localparam int CLK_REF = 0;
  localparam int CLK_DAT = 1;
  localparam int CLK_CNV = 2;
  localparam int NUM_CLK = 3;

  typedef struct packed {
    logic [NUM_CLK-1:0] rise;
    logic [NUM_CLK-1:0] fall;
    logic               pixMark;
    logic               quiet;
  } strobe_t;
endpackage

// File: rtl/afe_clkgen_ctrl.sv
`timescale 1ns/1ps
module afe_clkgen_ctrl
  import afe_clkgen_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int MIN_SAMPLE  = 1,
  parameter int MIN_CONV    = 2,
  parameter int MIN_PIX_3CH = 12,
  parameter int MIN_PIX_1CH = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             cdsMode,
  input  logic             threeCh,
  input  logic [CNT_W-1:0] refStart,
  input  logic [CNT_W-1:0] refWidth,
  input  logic [CNT_W-1:0] datStart,
  input  logic [CNT_W-1:0] datWidth,
  input  logic [CNT_W-1:0] cnvLow,
  input  logic [CNT_W-1:0] cnvHigh,
  output strobe_t          stb,
  output logic             cfgErr
);
  localparam int SLOT_W = CNT_W + 1;
  localparam int PER_W  = CNT_W + 3;

  function automatic logic badCfg(
    input logic cds, input logic three,
    input logic [CNT_W-1:0] rs, input logic [CNT_W-1:0] rw,
    input logic [CNT_W-1:0] ds, input logic [CNT_W-1:0] dw,
    input logic [CNT_W-1:0] lo, input logic [CNT_W-1:0] hi);
    logic [PER_W-1:0] slotLen;
    logic [PER_W-1:0] period;
    logic [PER_W-1:0] minPix;
    logic             bad;
    slotLen = PER_W'(lo) + PER_W'(hi);
    period  = three ? (slotLen + slotLen + slotLen) : (slotLen + slotLen);
    minPix  = three ? PER_W'(MIN_PIX_3CH) : PER_W'(MIN_PIX_1CH);
    bad = (dw < CNT_W'(MIN_SAMPLE)) || (lo < CNT_W'(MIN_CONV)) ||
          (hi < CNT_W'(MIN_CONV)) ||
          ((PER_W'(ds) + PER_W'(dw)) > PER_W'(lo)) || (period < minPix);
    if (cds) begin
      bad = bad || (rw < CNT_W'(MIN_SAMPLE)) ||
            ((PER_W'(rs) + PER_W'(rw)) > PER_W'(ds));
    end
    return bad;
  endfunction

  logic              running;
  logic              sCds, sThree;
  logic [CNT_W-1:0]  sRs, sRw, sDs, sDw, sLo, sHi;
  logic [SLOT_W-1:0] slotCnt;
  logic [1:0]        slotIdx;
  logic [SLOT_W-1:0] slotLen;
  logic [1:0]        lastIdx;
  logic              slotEnd, pixEnd, load, badIn;

  assign slotLen = SLOT_W'(sLo) + SLOT_W'(sHi);
  assign slotEnd = (slotCnt == slotLen - SLOT_W'(1));
  assign lastIdx = sThree ? 2'd2 : 2'd1;
  assign pixEnd  = running && slotEnd && (slotIdx == lastIdx);
  assign load    = !running || pixEnd;
  assign badIn   = badCfg(cdsMode, threeCh, refStart, refWidth,
                          datStart, datWidth, cnvLow, cnvHigh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      cfgErr  <= 1'b0;
      sCds    <= 1'b0;
      sThree  <= 1'b0;
      sRs     <= '0;
      sRw     <= '0;
      sDs     <= '0;
      sDw     <= '0;
      sLo     <= '0;
      sHi     <= '0;
      slotCnt <= '0;
      slotIdx <= '0;
    end else if (load) begin
      sCds    <= cdsMode;
      sThree  <= threeCh;
      sRs     <= refStart;
      sRw     <= refWidth;
      sDs     <= datStart;
      sDw     <= datWidth;
      sLo     <= cnvLow;
      sHi     <= cnvHigh;
      cfgErr  <= badIn;
      running <= run && !badIn;
      slotCnt <= '0;
      slotIdx <= '0;
    end else if (slotEnd) begin
      slotCnt <= '0;
      slotIdx <= slotIdx + 2'd1;
    end else begin
      slotCnt <= slotCnt + SLOT_W'(1);
    end
  end

  always_comb begin
    stb       = '0;
    stb.quiet = !running;
    if (running) begin
      stb.fall[CLK_CNV] = (slotCnt == '0);
      stb.rise[CLK_CNV] = (slotCnt == SLOT_W'(sLo));
      if (slotIdx == 2'd0) begin
        stb.rise[CLK_DAT] = (slotCnt == SLOT_W'(sDs));
        stb.fall[CLK_DAT] = (slotCnt == SLOT_W'(sDs) + SLOT_W'(sDw));
        stb.pixMark       = (slotCnt == SLOT_W'(sDs));
        if (sCds) begin
          stb.rise[CLK_REF] = (slotCnt == SLOT_W'(sRs));
          stb.fall[CLK_REF] = (slotCnt == SLOT_W'(sRs) + SLOT_W'(sRw));
        end
      end
    end
  end

  // slot index never passes the last slot of a pixel (R2, R9)
  assert_slot_limit_R2: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (slotIdx <= lastIdx));

  // a captured bad setting never leaves the generator running (R7)
  assert_err_stops_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !running);
endmodule

// File: rtl/afe_clkgen_dp.sv
`timescale 1ns/1ps
module afe_clkgen_dp
  import afe_clkgen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  output logic    refClk,
  output logic    datClk,
  output logic    cnvClk,
  output logic    pixStart
);
  logic [NUM_CLK-1:0] level;

  for (genvar i = 0; i < NUM_CLK; i++) begin : g_clk
    logic lvl;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              lvl <= 1'b0;
      else if (stb.quiet)     lvl <= 1'b0;
      else if (stb.rise[i])   lvl <= 1'b1;
      else if (stb.fall[i])   lvl <= 1'b0;
    end
    assign level[i] = lvl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pixStart <= 1'b0;
    else       pixStart <= stb.pixMark && !stb.quiet;
  end

  assign refClk = level[CLK_REF];
  assign datClk = level[CLK_DAT];
  assign cnvClk = level[CLK_CNV];

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(refClk && datClk));

  assert_dat_fall_early_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(datClk) |-> !$past(cnvClk));

  assert_pix_on_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    pixStart |-> (datClk && !$past(datClk)));
endmodule

// File: rtl/afe_clkgen.sv
`timescale 1ns/1ps
module afe_clkgen
  import afe_clkgen_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int MIN_SAMPLE  = 1,
  parameter int MIN_CONV    = 2,
  parameter int MIN_PIX_3CH = 12,
  parameter int MIN_PIX_1CH = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             cdsMode,
  input  logic             threeCh,
  input  logic [CNT_W-1:0] refStart,
  input  logic [CNT_W-1:0] refWidth,
  input  logic [CNT_W-1:0] datStart,
  input  logic [CNT_W-1:0] datWidth,
  input  logic [CNT_W-1:0] cnvLow,
  input  logic [CNT_W-1:0] cnvHigh,
  output logic             refClk,
  output logic             datClk,
  output logic             cnvClk,
  output logic             pixStart,
  output logic             cfgErr
);
  strobe_t stb;

  afe_clkgen_ctrl #(
    .CNT_W(CNT_W), .MIN_SAMPLE(MIN_SAMPLE), .MIN_CONV(MIN_CONV),
    .MIN_PIX_3CH(MIN_PIX_3CH), .MIN_PIX_1CH(MIN_PIX_1CH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .run(run), .cdsMode(cdsMode), .threeCh(threeCh),
    .refStart(refStart), .refWidth(refWidth), .datStart(datStart),
    .datWidth(datWidth), .cnvLow(cnvLow), .cnvHigh(cnvHigh),
    .stb(stb), .cfgErr(cfgErr)
  );

  afe_clkgen_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .refClk(refClk), .datClk(datClk), .cnvClk(cnvClk), .pixStart(pixStart)
  );
endmodule

// File: tb/afe_clkgen_test.sv
`timescale 1ns/1ps
module afe_clkgen_test;
  localparam int CNT_W = 8;

  typedef struct {
    bit cds;
    bit three;
    int rs, rw, ds, dw, lo, hi;
  } tcfg_t;

  typedef struct {
    logic [3:0] v;   // {ref, dat, cnv, pix}
    string      tRef, tDat, tCnv, tPix;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic run = 1'b0;
  logic cdsMode = 1'b0;
  logic threeCh = 1'b0;
  logic [CNT_W-1:0] refStart = '0, refWidth = '0, datStart = '0;
  logic [CNT_W-1:0] datWidth = '0, cnvLow = '0, cnvHigh = '0;
  logic refClk, datClk, cnvClk, pixStart, cfgErr;

  int checks = 0;
  int fails = 0;
  item_t q[$];

  always #10 clk = ~clk;

  afe_clkgen uut (
    .clk(clk), .rstN(rstN), .run(run), .cdsMode(cdsMode), .threeCh(threeCh),
    .refStart(refStart), .refWidth(refWidth), .datStart(datStart),
    .datWidth(datWidth), .cnvLow(cnvLow), .cnvHigh(cnvHigh),
    .refClk(refClk), .datClk(datClk), .cnvClk(cnvClk),
    .pixStart(pixStart), .cfgErr(cfgErr)
  );

  task automatic check1(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int pixLen(tcfg_t c);
    return (c.three ? 3 : 2) * (c.lo + c.hi);
  endfunction

  function automatic item_t expAt(tcfg_t c, int g);
    item_t it;
    int slot, s, idx;
    bit r, d, v, p;
    slot = c.lo + c.hi;
    s    = g % slot;
    idx  = (g / slot) % (c.three ? 3 : 2);
    v = (s >= c.lo);
    d = (idx == 0) && (s >= c.ds) && (s < c.ds + c.dw);
    r = c.cds && (idx == 0) && (s >= c.rs) && (s < c.rs + c.rw);
    p = (idx == 0) && (s == c.ds);
    it.v    = {r, d, v, p};
    it.tRef = c.cds ? "R4" : "R5";
    it.tDat = "R3";
    it.tCnv = c.three ? "R2" : "R9";
    it.tPix = "R6";
    return it;
  endfunction

  task automatic applyCfg(tcfg_t c);
    cdsMode  = c.cds;
    threeCh  = c.three;
    refStart = CNT_W'(c.rs);
    refWidth = CNT_W'(c.rw);
    datStart = CNT_W'(c.ds);
    datWidth = CNT_W'(c.dw);
    cnvLow   = CNT_W'(c.lo);
    cnvHigh  = CNT_W'(c.hi);
  endtask

  // driver: runs na pixels of a then nb pixels of b, pushing the expected stream
  task automatic runStream(tcfg_t a, int na, tcfg_t b, int nb);
    item_t z;
    @(negedge clk);
    applyCfg(a);
    run = 1'b1;
    @(negedge clk);
    #1;
    for (int g = 0; g < na * pixLen(a); g++) q.push_back(expAt(a, g));
    for (int g = 0; g < nb * pixLen(b); g++) q.push_back(expAt(b, g));
    z.v = 4'b0000; z.tRef = "R8"; z.tDat = "R8"; z.tCnv = "R8"; z.tPix = "R8";
    for (int k = 0; k < 3; k++) q.push_back(z);
    repeat (na * pixLen(a) - 1) @(negedge clk);
    if (nb > 0) begin
      applyCfg(b);   // R8: lands in the last count of pixel na
      repeat (nb * pixLen(b)) @(negedge clk);
    end
    run = 1'b0;      // R8: seen at the last count, generator stops
    while (q.size() > 0) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    item_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        check1(e.tRef, refClk,   e.v[3], "refClk");
        check1(e.tDat, datClk,   e.v[2], "datClk");
        check1(e.tCnv, cnvClk,   e.v[1], "cnvClk");
        check1(e.tPix, pixStart, e.v[0], "pixStart");
      end
    end
  end

  task automatic checkErr(tcfg_t c, tcfg_t good);
    @(negedge clk);
    applyCfg(c);
    run = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check1("R7", cfgErr, 1'b1, "cfgErr");
      check1("R7", refClk | datClk | cnvClk | pixStart, 1'b0, "any clock");
    end
    run = 1'b0;
    applyCfg(good);
    repeat (2) @(negedge clk);
    check1("R7", cfgErr, 1'b0, "cfgErr after valid settings");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    tcfg_t cA, cB, cC, cD, e1, e2, e3, e4, e5;
    cA = '{cds:1, three:1, rs:0, rw:2, ds:3, dw:2, lo:5, hi:3};  // dat fall == cnv rise
    cB = '{cds:0, three:1, rs:1, rw:9, ds:1, dw:3, lo:4, hi:4};  // ref fields would clash in CDS
    cC = '{cds:1, three:0, rs:1, rw:1, ds:2, dw:1, lo:4, hi:2};  // ref fall == dat rise
    cD = '{cds:0, three:0, rs:0, rw:0, ds:0, dw:3, lo:3, hi:2};  // period exactly the minimum
    e1 = '{cds:1, three:1, rs:2, rw:2, ds:3, dw:2, lo:5, hi:3};  // ref overlaps dat
    e2 = '{cds:1, three:1, rs:0, rw:2, ds:3, dw:3, lo:5, hi:3};  // dat past cnv rise
    e3 = '{cds:0, three:0, rs:0, rw:0, ds:0, dw:2, lo:2, hi:2};  // one-channel period 8 < 10
    e4 = '{cds:0, three:1, rs:0, rw:0, ds:1, dw:0, lo:4, hi:4};  // zero data width
    e5 = '{cds:0, three:1, rs:0, rw:0, ds:0, dw:1, lo:4, hi:1};  // cnv high too short

    // R1: reset state
    repeat (3) @(negedge clk);
    check1("R1", refClk | datClk | cnvClk | pixStart, 1'b0, "clocks in reset");
    check1("R1", cfgErr, 1'b0, "cfgErr in reset");
    applyCfg(cA);
    rstN = 1'b1;
    @(negedge clk);
    check1("R1", refClk | datClk | cnvClk | pixStart, 1'b0, "clocks after reset");
    check1("R1", cfgErr, 1'b0, "cfgErr after reset");

    runStream(cA, 2, cA, 0);   // R2 R3 R4 R6
    runStream(cB, 2, cB, 0);   // R5
    runStream(cC, 3, cC, 0);   // R9
    runStream(cD, 2, cD, 0);   // R9 R5
    runStream(cA, 2, cC, 2);   // R8 switch three -> one channel
    runStream(cD, 1, cB, 1);   // R8 switch one -> three channel

    checkErr(e1, cA);
    checkErr(e2, cA);
    checkErr(e3, cA);
    checkErr(e4, cA);
    checkErr(e5, cA);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule